// File: doc/BRIEF.md
# Dual Timer Register Wrapper

This block places two independent down-counting timer channels behind a 32-bit peripheral bus port with a 4 KB address space. The address space below 0xF00 is cut into 32-byte windows, one per channel, selected by address bit 5. The upper end of the space holds a test-control register, a write-only test-output register, and a twelve-word block of read-only identification bytes. Each channel counts down from a programmable reload value. It can be clocked every cycle or through a prescaler of 16 or 256. It can work as a 16-bit or a 32-bit counter, and it can be set to wrap to all ones, reload periodically, or stop after one pass. It raises a sticky status flag each time its count steps from one to zero.

Each channel drives its own interrupt output, gated by that channel's interrupt-enable bit. A third output is the OR of the two channel outputs. Setting the test-control bit disconnects the live interrupt state from the outputs and drives them from the test-output bits instead, so a system can check its interrupt wiring without running the counters. Every register write takes effect at the clock edge that ends the access phase of a bus write. The ready output is tied high, so no access ever waits.

Top module: `dual_timer_wrap`

## Requirements
- R1: Offsets below 0xF00 whose index (offset / 32) is 0 or 1 reach channel 0 or channel 1. Within a window, word offset 0x00 is reload (immediate), 0x04 is count, 0x08 is control, 0x0C is status clear, 0x10 is raw status, 0x14 is masked status and 0x18 is reload (background). A write to one channel leaves the other channel unchanged.
- R2: A write to the immediate reload word sets both the reload and the count to the written data. A write to the background reload word sets only the reload. A read of either reload word returns the reload value.
- R3: The control word keeps only bits 0,1,2,3,5,6,7 (mask 0xEF) and reads back as stored. Bit 7 enables counting. Bits 3:2 pick the step rate: 0 steps every clock, 1 every 16th clock, 2 and 3 every 256th clock, with the first step 16 or 256 clocks after the enabling control write. Bit 1 set gives a 32-bit counter. Bit 1 clear gives a 16-bit counter in which only the low 16 bits of the count change and the upper 16 read back as last written.
- R4: When a step takes the count (at the selected width) from 1 to 0, raw status (bit 0) becomes 1 and stays 1 until a write to the status-clear word. Masked status is raw status AND control bit 5.
- R5: A step taken at count 0 reloads the reload value when control bit 6 is set. When bit 6 is clear it loads all ones at the selected width. When control bit 0 (single pass) is set, the count stays at 0.
- R6: The test-control register at 0xF00 holds one enable bit at bit 0 and reads back. The test-output register at 0xF04 holds interrupt 0 at bit 0 and interrupt 1 at bit 1, and reads as zero.
- R7: While the test-control bit is 1, the two channel interrupt outputs equal the test-output bits. While it is 0, they equal each channel's masked status.
- R8: The combined interrupt output is the OR of the two channel interrupt outputs.
- R9: Words 0xFD0 to 0xFFC read the bytes 04,00,00,00,23,B8,1B,00,0D,F0,05,B1, one byte per word in rising address order, zero-extended to 32 bits.
- R10: Any other offset, including channel index 2 and above and the unused channel words 0x0C and 0x1C, reads zero. Writes to those offsets change nothing.
- R11: After reset, each channel has control 0x20, reload 0, count 0xFFFFFFFF and raw status 0. Test control and test output are 0, and all interrupt outputs are low.
- R12: The ready output is always 1. Read data is driven from the addressed register while select is high and write is low, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pSel | input | 1 | Peripheral select |
| pEnable | input | 1 | Access-phase strobe |
| pWrite | input | 1 | 1 for write, 0 for read |
| pAddr | input | ADDR_W | Byte offset within the 4 KB window |
| pWdata | input | DATA_W | Write data |
| pRdata | output | DATA_W | Read data |
| pReady | output | 1 | Transfer ready, tied high |
| irqA | output | 1 | Channel 0 interrupt |
| irqB | output | 1 | Channel 1 interrupt |
| irqAny | output | 1 | OR of both channel interrupts |

## Verification
The bench uses the default parameters: a 12-bit offset, 32-bit data and an 8-bit prescaler. With these values the slowest step rate, 256 clocks, completes within a few hundred cycles, so both prescale boundaries are checked on the exact cycle. The 32-bit data width also lets a 16-bit wrap be checked while the upper half of the count stays unchanged. All counting checks are timed from the bus edge that commits the enabling write.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

  localparam int NUM_CH = 2;

  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PRE_LO   = 2;
  localparam int CB_IRQEN    = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_RUN      = 7;
  localparam logic [7:0] CTRL_KEEP  = 8'hEF;
  localparam logic [7:0] CTRL_RESET = 8'h20;

  typedef struct packed {
    logic [NUM_CH-1:0] wrLoad;
    logic [NUM_CH-1:0] wrBgLoad;
    logic [NUM_CH-1:0] wrCtrl;
    logic [NUM_CH-1:0] wrClr;
    logic              wrTestCtl;
    logic              wrTestOut;
  } dtwStrobe_t;

  typedef enum logic [2:0] {
    RD_ZERO, RD_RELOAD, RD_COUNT, RD_CTRL, RD_RAW, RD_MASKED, RD_TESTCTL, RD_IDENT
  } rdKind_t;

  typedef struct packed {
    rdKind_t    kind;
    logic       ch;
    logic [3:0] idIdx;
  } dtwRdSel_t;

  function automatic logic [7:0] identByte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h23;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/dtw_channel.sv
module dtw_channel
  import dtw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int PRE_W   = 8,
  parameter int PRE_MID = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLoad,
  input  logic              wrBgLoad,
  input  logic              wrCtrl,
  input  logic              wrClr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count,
  output logic [7:0]        ctrl,
  output logic              raw,
  output logic              masked
);

  localparam int ZW = DATA_W - HALF_W;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] cur, nxt, merged;
  logic              run, wide, tick, atOne;

  assign run  = ctrl[CB_RUN];
  assign wide = ctrl[CB_WIDE];

  always_comb begin
    tick = 1'b0;
    if (run && !wrCtrl) begin
      case (ctrl[CB_PRE_LO +: 2])
        2'd0:    tick = 1'b1;
        2'd1:    tick = &preCnt[PRE_MID-1:0];
        default: tick = &preCnt;
      endcase
    end
  end

  always_comb begin
    cur   = wide ? count : {{ZW{1'b0}}, count[HALF_W-1:0]};
    atOne = (cur == ONE);
    if (cur == '0) begin
      if (ctrl[CB_ONESHOT])       nxt = cur;
      else if (ctrl[CB_PERIODIC]) nxt = wide ? reload : {{ZW{1'b0}}, reload[HALF_W-1:0]};
      else                        nxt = wide ? ONES : {{ZW{1'b0}}, {HALF_W{1'b1}}};
    end else begin
      nxt = cur - ONE;
    end
    merged = wide ? nxt : {count[DATA_W-1:HALF_W], nxt[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      ctrl   <= CTRL_RESET;
      reload <= '0;
      count  <= ONES;
      raw    <= 1'b0;
    end else begin
      if (!run || wrCtrl) preCnt <= '0;
      else                preCnt <= preCnt + 1'b1;
      if (wrCtrl) ctrl <= wdata[7:0] & CTRL_KEEP;
      if (wrLoad || wrBgLoad) reload <= wdata;
      if (wrLoad)    count <= wdata;
      else if (tick) count <= merged;
      if (tick && atOne) raw <= 1'b1;
      else if (wrClr)    raw <= 1'b0;
    end
  end

  assign masked = raw & ctrl[CB_IRQEN];

endmodule

// File: rtl/dtw_ctrl.sv
module dtw_ctrl
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  output dtwStrobe_t        strobe,
  output dtwRdSel_t         rdSel,
  output logic              rdActive
);

  localparam logic [ADDR_W-1:0] OFF_TESTCTL = ADDR_W'(12'hF00);
  localparam logic [ADDR_W-1:0] OFF_TESTOUT = ADDR_W'(12'hF04);
  localparam logic [ADDR_W-1:0] OFF_IDENT   = ADDR_W'(12'hFD0);
  localparam logic [ADDR_W-3:0] ID_WORD0    = OFF_IDENT[ADDR_W-1:2];
  localparam int               CH_HI        = ADDR_W - 1;

  logic              wrEn, chOk, chSel, isTestCtl, isTestOut, isIdent;
  logic [2:0]        regIdx;
  logic [ADDR_W-3:0] idWord;

  assign wrEn      = pSel && pEnable && pWrite;
  assign rdActive  = pSel && !pWrite;
  assign chOk      = (pAddr < OFF_TESTCTL) && (pAddr[CH_HI:6] == '0);
  assign chSel     = pAddr[5];
  assign regIdx    = pAddr[4:2];
  assign isTestCtl = (pAddr[ADDR_W-1:2] == OFF_TESTCTL[ADDR_W-1:2]);
  assign isTestOut = (pAddr[ADDR_W-1:2] == OFF_TESTOUT[ADDR_W-1:2]);
  assign isIdent   = (pAddr >= OFF_IDENT);
  assign idWord    = pAddr[ADDR_W-1:2] - ID_WORD0;

  always_comb begin
    strobe = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wrEn && chOk && (chSel == 1'(c))) begin
        strobe.wrLoad[c]   = (regIdx == 3'd0);
        strobe.wrCtrl[c]   = (regIdx == 3'd2);
        strobe.wrClr[c]    = (regIdx == 3'd3);
        strobe.wrBgLoad[c] = (regIdx == 3'd6);
      end
    end
    strobe.wrTestCtl = wrEn && isTestCtl;
    strobe.wrTestOut = wrEn && isTestOut;
  end

  always_comb begin
    rdSel       = '0;
    rdSel.kind  = RD_ZERO;
    rdSel.ch    = chSel;
    rdSel.idIdx = idWord[3:0];
    if (chOk) begin
      case (regIdx)
        3'd0, 3'd6: rdSel.kind = RD_RELOAD;
        3'd1:       rdSel.kind = RD_COUNT;
        3'd2:       rdSel.kind = RD_CTRL;
        3'd4:       rdSel.kind = RD_RAW;
        3'd5:       rdSel.kind = RD_MASKED;
        default:    rdSel.kind = RD_ZERO;
      endcase
    end else if (isTestCtl) begin
      rdSel.kind = RD_TESTCTL;
    end else if (isIdent) begin
      rdSel.kind = RD_IDENT;
    end
  end

endmodule

// File: rtl/dtw_datapath.sv
module dtw_datapath
  import dtw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtwStrobe_t        strobe,
  input  dtwRdSel_t         rdSel,
  input  logic              rdActive,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irqCh,
  output logic              irqAny
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] chReload [NUM_CH];
  logic [DATA_W-1:0] chCount  [NUM_CH];
  logic [7:0]        chCtrl   [NUM_CH];
  logic [NUM_CH-1:0] chRaw, chMasked;
  logic              testCtl;
  logic [NUM_CH-1:0] testOut;
  logic [DATA_W-1:0] muxOut;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    dtw_channel #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W),
      .PRE_W  (PRE_W),
      .PRE_MID(PRE_W / 2)
    ) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .wrLoad  (strobe.wrLoad[c]),
      .wrBgLoad(strobe.wrBgLoad[c]),
      .wrCtrl  (strobe.wrCtrl[c]),
      .wrClr   (strobe.wrClr[c]),
      .wdata   (wdata),
      .reload  (chReload[c]),
      .count   (chCount[c]),
      .ctrl    (chCtrl[c]),
      .raw     (chRaw[c]),
      .masked  (chMasked[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testCtl <= 1'b0;
      testOut <= '0;
    end else begin
      if (strobe.wrTestCtl) testCtl <= wdata[0];
      if (strobe.wrTestOut) testOut <= wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    case (rdSel.kind)
      RD_RELOAD:  muxOut = chReload[rdSel.ch];
      RD_COUNT:   muxOut = chCount[rdSel.ch];
      RD_CTRL:    muxOut = DATA_W'(chCtrl[rdSel.ch]);
      RD_RAW:     muxOut = DATA_W'(chRaw[rdSel.ch]);
      RD_MASKED:  muxOut = DATA_W'(chMasked[rdSel.ch]);
      RD_TESTCTL: muxOut = DATA_W'(testCtl);
      RD_IDENT:   muxOut = DATA_W'(identByte(rdSel.idIdx));
      default:    muxOut = '0;
    endcase
  end

  assign rdata  = rdActive ? muxOut : '0;
  assign irqCh  = testCtl ? testOut : chMasked;
  assign irqAny = |irqCh;

endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  output logic              pReady,
  output logic              irqA,
  output logic              irqB,
  output logic              irqAny
);

  dtwStrobe_t        strobe;
  dtwRdSel_t         rdSel;
  logic              rdActive;
  logic [NUM_CH-1:0] irqCh;

  dtw_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .pAddr   (pAddr),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .rdActive(rdActive)
  );

  dtw_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .rdActive(rdActive),
    .wdata   (pWdata),
    .rdata   (pRdata),
    .irqCh   (irqCh),
    .irqAny  (irqAny)
  );

  assign pReady = 1'b1;
  assign irqA   = irqCh[0];
  assign irqB   = irqCh[1];

endmodule

// File: rtl/dual_timer_wrap_chk.sv
module dual_timer_wrap_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              pSel,
  input logic              pEnable,
  input logic              pWrite,
  input logic [ADDR_W-1:0] pAddr,
  input logic [DATA_W-1:0] pWdata,
  input logic [DATA_W-1:0] pRdata,
  input logic              pReady,
  input logic              irqA,
  input logic              irqB,
  input logic              irqAny
);

  logic       shadowTest, sawOutWrite;
  logic [1:0] shadowOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowTest  <= 1'b0;
      shadowOut   <= 2'b00;
      sawOutWrite <= 1'b0;
    end else begin
      sawOutWrite <= 1'b0;
      if (pSel && pEnable && pWrite && pAddr == ADDR_W'(12'hF00)) shadowTest <= pWdata[0];
      if (pSel && pEnable && pWrite && pAddr == ADDR_W'(12'hF04)) begin
        shadowOut   <= pWdata[1:0];
        sawOutWrite <= 1'b1;
      end
    end
  end

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rstN) pReady); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pSel |-> pRdata == '0); // R12
  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqA || irqB)); // R8
  AST_IDENT_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !pWrite && pAddr == ADDR_W'(12'hFE0)) |-> pRdata == DATA_W'(32'h23)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !pWrite && pAddr >= ADDR_W'(12'h040) && pAddr < ADDR_W'(12'hF00)) |-> pRdata == '0); // R10
  AST_TEST_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (sawOutWrite && shadowTest) |-> (irqA == shadowOut[0] && irqB == shadowOut[1])); // R7

endmodule

bind dual_timer_wrap dual_timer_wrap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/dual_timer_wrap_test.sv
module dual_timer_wrap_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [11:0] pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        pReady, irqA, irqB, irqAny;

  int    nChecks = 0;
  int    nFail   = 0;
  bit    done    = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  dual_timer_wrap uut (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .irqA(irqA), .irqB(irqB), .irqAny(irqAny)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: each bus task spans three falling edges; a write commits on its
  // third rising edge, a read is sampled after its second rising edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); pSel = 1; pEnable = 0; pWrite = 1; pAddr = a; pWdata = d;
    @(negedge clk); pEnable = 1;
    @(negedge clk); pSel = 0; pEnable = 0; pWrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk); pSel = 1; pEnable = 0; pWrite = 0; pAddr = a;
    @(negedge clk); pEnable = 1;
    @(negedge clk); pSel = 0; pEnable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkIrq(input string tag, input logic a, input logic b);
    #1;
    check({tag, " irqA"}, {31'b0, irqA}, {31'b0, a});
    check({tag, " irqB"}, {31'b0, irqB}, {31'b0, b});
    check({tag, " irqAny"}, {31'b0, irqAny}, {31'b0, a | b});
  endtask

  // monitor: compares every read access phase against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (pSel && pEnable && !pWrite) begin
        if (expQ.size() == 0) check("R12 unexpected read", pRdata, 32'h0);
        else check(tagQ.pop_front(), pRdata, expQ.pop_front());
      end
    end
  end

  initial begin
    #(50000 * 10);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] idBytes [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    idle(3);
    rstN = 1'b1;
    idle(1);

    // reset state
    #1 check("R12 ready", {31'b0, pReady}, 32'h1);
    checkIrq("R11 reset", 0, 0);
    busRead(12'h008, 32'h20, "R11 ctrl0");
    busRead(12'h028, 32'h20, "R11 ctrl1");
    busRead(12'h004, 32'hFFFF_FFFF, "R11 count0");
    busRead(12'h000, 32'h0, "R11 reload0");
    busRead(12'h030, 32'h0, "R11 raw1");
    busRead(12'hF00, 32'h0, "R11 testctl");

    // decode, immediate and background reload
    busWrite(12'h020, 32'h1234_5678);
    busRead(12'h020, 32'h1234_5678, "R2 reload1");
    busRead(12'h024, 32'h1234_5678, "R2 count1");
    busRead(12'h038, 32'h1234_5678, "R2 bgreload1 read");
    busRead(12'h000, 32'h0, "R1 channel0 untouched");
    busWrite(12'h038, 32'hCAFE_0001);
    busRead(12'h020, 32'hCAFE_0001, "R2 reload after bg");
    busRead(12'h024, 32'h1234_5678, "R2 count kept after bg");

    // control mask
    busWrite(12'h028, 32'h0000_007E);
    busRead(12'h028, 32'h6E, "R3 ctrl mask");
    busWrite(12'h028, 32'h20);

    // unmapped
    busWrite(12'h040, 32'hDEAD_BEEF);
    busWrite(12'h01C, 32'hDEAD_BEEF);
    busRead(12'h000, 32'h0, "R10 write ignored ch0");
    busRead(12'h020, 32'hCAFE_0001, "R10 write ignored ch1");
    busRead(12'h040, 32'h0, "R10 read idx2");
    busRead(12'h01C, 32'h0, "R10 read 0x1C");
    busRead(12'h00C, 32'h0, "R10 read clear word");
    busRead(12'hF08, 32'h0, "R10 read 0xF08");

    // ch0 periodic 32-bit, step every clock, reload 4
    busWrite(12'h000, 32'd4);
    busWrite(12'h008, 32'hE2);
    busRead(12'h004, 32'd2, "R3 count after 2 steps");
    busRead(12'h010, 32'h1, "R4 raw set at zero");
    busRead(12'h004, 32'd1, "R5 periodic reload");
    checkIrq("R4 ch0 irq", 1, 0);
    busWrite(12'h008, 32'h62);
    busRead(12'h004, 32'd3, "R3 stop on disable");
    busRead(12'h014, 32'h1, "R4 masked");
    busWrite(12'h00C, 32'h0);
    busRead(12'h010, 32'h0, "R4 raw cleared");
    checkIrq("R4 ch0 cleared", 0, 0);

    // ch0 free-running 16-bit wrap, upper half kept
    busWrite(12'h008, 32'h20);
    busWrite(12'h000, 32'h0001_0001);
    busWrite(12'h008, 32'hA0);
    busRead(12'h004, 32'h0001_FFFF, "R5 16-bit free wrap");
    busWrite(12'h008, 32'h20);
    busRead(12'h004, 32'h0001_FFFC, "R3 16-bit steps");
    busRead(12'h000, 32'h0001_0001, "R2 reload unchanged");
    busWrite(12'h00C, 32'h0);

    // ch1 single pass, interrupt enable off then on
    busWrite(12'h020, 32'd2);
    busWrite(12'h028, 32'h83);
    busRead(12'h024, 32'd0, "R5 single pass reaches zero");
    busRead(12'h024, 32'd0, "R5 single pass holds");
    busRead(12'h030, 32'h1, "R4 raw ch1");
    busRead(12'h034, 32'h0, "R4 masked off");
    checkIrq("R4 masked irq off", 0, 0);
    busWrite(12'h028, 32'hA3);
    busRead(12'h034, 32'h1, "R4 masked on");
    checkIrq("R8 ch1 irq", 0, 1);
    busWrite(12'h02C, 32'h0);
    checkIrq("R4 ch1 cleared", 0, 0);

    // prescale by 16
    busWrite(12'h028, 32'h02);
    busWrite(12'h020, 32'd100);
    busWrite(12'h028, 32'hC6);
    idle(13);
    busRead(12'h024, 32'd100, "R3 div16 before step");
    busRead(12'h024, 32'd99, "R3 div16 first step");

    // prescale code 3 acts as 256
    busWrite(12'h028, 32'h02);
    busWrite(12'h020, 32'd50);
    busWrite(12'h028, 32'hCE);
    idle(253);
    busRead(12'h024, 32'd50, "R3 div256 before step");
    busRead(12'h024, 32'd49, "R3 div256 first step");
    busWrite(12'h028, 32'h02);

    // identification words
    for (int i = 0; i < 12; i++)
      busRead(12'hFD0 + 12'(4 * i), {24'h0, idBytes[i]}, $sformatf("R9 id word %0d", i));

    // test mode
    busWrite(12'hF04, 32'h2);
    checkIrq("R7 test bits ignored when off", 0, 0);
    busWrite(12'hF00, 32'h1);
    checkIrq("R7 test drive b", 0, 1);
    busRead(12'hF00, 32'h1, "R6 testctl readback");
    busRead(12'hF04, 32'h0, "R6 testout reads zero");
    busWrite(12'hF04, 32'h1);
    checkIrq("R7 test drive a", 1, 0);
    busWrite(12'hF04, 32'h3);
    checkIrq("R8 both forced", 1, 1);
    busWrite(12'hF00, 32'h0);
    checkIrq("R7 back to live", 0, 0);

    idle(3);
    #1 check("R1 scoreboard drained", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule